// File: doc/BRIEF.md
# Self-Synchronizing Space-Vector Dwell Calculator

This block computes, once per switching period, how long a three-phase boost rectifier should apply each of two active voltage vectors and the null vector. It does this without measuring the line voltage. A start pulse supplies the alpha and beta line-current samples taken at the start of the period, a current-sense gain, the output of the outer voltage regulator and the period length in clock counts. For each axis the block forms a trough-current off-time, (1 − d)·Ts. The duty follows d = 1 − gain·i/Vm, where i is the current at the start of the period, which is also the current at the end of the previous one.

The block holds an estimate of the sector in which the line voltage lies. It folds the two currents into positive magnitudes according to that sector and solves one of two pairs of dwell equations. If the result is not valid (an axis duty of one or more, or a second dwell time that is not positive), the block steps to the next sector in a fixed eight-step cycle and solves again within the same period. When a sector is accepted, it becomes the starting guess for the next period. In this way the switching locks onto the line voltage by itself. If none of the eight sectors gives a valid result, the block keeps its previous sector, issues a full-null period and raises a fault flag.

Top module: `svm_dwell_sync`

## Requirements
- R1: Reset state: sector code 0, `t1`, `t2` and `t0` all 0, `done` 0, `fault` 0, `vec_pair` = octal 12.
- R2: Sector codes 0..7 stand for sectors 1, 2A, 2B, 3, 4, 5A, 5B, 6. A search starts at the held code and steps to code+1, with 7 wrapping to 0.
- R3: Folding: the alpha sample is negated for codes 2, 3, 4 and 5, and the beta sample for codes 4, 5, 6 and 7. A folded value below zero counts as zero. The magnitude is m.
- R4: Per axis, p = floor(gain·m/2^15). The off-time is 0 when p = 0, equals Ts when p ≥ Vm (this includes Vm = 0), and is otherwise floor(Ts·p/Vm).
- R5: Codes 0, 3, 4 and 7 (offs oa, ob): T1 = floor(ob/2) and T2 = oa − floor(T1·28378/2^14).
- R6: Codes 1, 2, 5 and 6 exchange the axes: T1 = floor(oa/2) and T2 = ob − floor(T1·28378/2^14).
- R7: A sector is accepted only when oa > 0, ob > 0 and T2 > 0. Otherwise the next code is tried in the same period.
- R8: On acceptance, T0 = Ts − T1 − T2, and the accepted code becomes the held sector.
- R9: After 8 rejected attempts, the held sector is kept, T1 = T2 = 0, T0 = Ts and `fault` = 1. The next accepted period clears `fault`.
- R10: `done` is high for one clock, exactly 19·n clocks after the edge that samples `start`, where n is the number of attempts. All other outputs change only on that clock.
- R11: The inputs are captured at the edge that accepts `start`. A `start` pulse during a search is ignored, and so are input changes during it.
- R12: `vec_pair` = {first, second} vector index in 3 bits each, per code 0..7: 12, 23, 32, 34, 45, 56, 65, 61 (octal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one period's calculation |
| i_alpha | input | 16 | Signed alpha current sample |
| i_beta | input | 16 | Signed beta current sample |
| rs_gain | input | 16 | Unsigned current-sense gain, Q1.15 |
| v_ctrl | input | 16 | Unsigned voltage-regulator output Vm |
| period_cnt | input | 16 | Switching period Ts in counts |
| sector | output | 3 | Held sector code |
| vec_pair | output | 6 | Active-vector pair for the held sector |
| t1 | output | 16 | First active-vector dwell, counts |
| t2 | output | 16 | Second active-vector dwell, counts |
| t0 | output | 16 | Null-vector dwell, counts |
| done | output | 1 | One-clock result strobe |
| fault | output | 1 | No sector accepted in the last period |

## Verification
Currents are placed in each quadrant at shallow and steep angles. A shallow angle is accepted by the first equation group, while a steep angle forces a step into the exchanged group, so the fold signs and both solvers are told apart. Runs that need one, two, four and eight attempts check the search latency and the wrap from code 7 to code 0. All-zero currents exercise the fault path and its later clearing. Over-range currents and a zero regulator output exercise the saturated off-time. A second start pulse, given mid-search together with changed inputs, must leave the result unchanged.

// File: rtl/svm_dwell_pkg.sv
package svm_dwell_pkg;

    localparam int SECTOR_COUNT = 8;
    localparam int SECTOR_BITS  = $clog2(SECTOR_COUNT);
    localparam int SQRT3_FRAC   = 14;
    localparam logic [15:0] SQRT3_Q = 16'd28378;  // sqrt(3) in Q2.14
    localparam int AXES         = 2;

    typedef logic [SECTOR_BITS-1:0] sector_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_SOLVE
    } state_t;

    // Sign flips and equation-group choice for one sector
    typedef struct packed {
        logic neg_a;
        logic neg_b;
        logic swap;
    } fold_t;

    function automatic fold_t sector_fold(sector_t s);
        fold_t f;
        case (s)
            3'd0:    f = 3'b000;
            3'd1:    f = 3'b001;
            3'd2:    f = 3'b101;
            3'd3:    f = 3'b100;
            3'd4:    f = 3'b110;
            3'd5:    f = 3'b111;
            3'd6:    f = 3'b011;
            default: f = 3'b010;
        endcase
        return f;
    endfunction

    function automatic sector_t sector_next(sector_t s);
        return s + sector_t'(1);
    endfunction

    function automatic logic [5:0] sector_pair(sector_t s);
        logic [5:0] p;
        case (s)
            3'd0:    p = 6'o12;
            3'd1:    p = 6'o23;
            3'd2:    p = 6'o32;
            3'd3:    p = 6'o34;
            3'd4:    p = 6'o45;
            3'd5:    p = 6'o56;
            3'd6:    p = 6'o65;
            default: p = 6'o61;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/svm_frac_div.sv
// Restoring divider, one quotient bit per clock. The caller guarantees
// num[2DW-1:DW] < den whenever the quotient is used.
module svm_frac_div #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [2*DW-1:0] num,
    input  logic [DW-1:0]   den,
    output logic            busy,
    output logic [DW-1:0]   quo
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] rem_q, quo_q, den_q;
    logic [CW-1:0] cnt_q;
    logic [DW:0]   rem_sh, rem_sub;

    always_comb begin
        rem_sh  = {rem_q, quo_q[DW-1]};
        rem_sub = rem_sh - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= num[2*DW-1:DW];
            quo_q <= num[DW-1:0];
            den_q <= den;
            cnt_q <= CW'(DW);
        end else if (cnt_q != '0) begin
            if (!rem_sub[DW]) begin
                rem_q <= rem_sub[DW-1:0];
                quo_q <= {quo_q[DW-2:0], 1'b1};
            end else begin
                rem_q <= rem_sh[DW-1:0];
                quo_q <= {quo_q[DW-2:0], 1'b0};
            end
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign busy = (cnt_q != '0);
    assign quo  = quo_q;

endmodule

// File: rtl/svm_axis_offtime.sv
// One axis: fold the sample, scale by the sense gain, and turn the
// ratio against the regulator output into an off-time in counts.
module svm_axis_offtime #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic signed [DW-1:0] sample,
    input  logic                 neg,
    input  logic [DW-1:0]        rs,
    input  logic [DW-1:0]        vm,
    input  logic [DW-1:0]        ts,
    output logic                 busy,
    output logic [DW-1:0]        off
);
    localparam int MW = DW + 1;        // folded magnitude width
    localparam int PW = DW + MW;       // gain product width
    localparam int SW = DW + 2;        // scaled current width

    logic signed [MW-1:0] ext, folded;
    logic [MW-1:0]        mag;
    logic [PW-1:0]        prod;
    logic [SW-1:0]        p;
    logic [2*DW-1:0]      num;
    logic                 is_zero, is_full;
    logic                 zero_q, full_q;
    logic [DW-1:0]        ts_l, quo;

    always_comb begin
        ext    = {sample[DW-1], sample};
        folded = neg ? -ext : ext;
        mag    = folded[MW-1] ? '0 : folded;
        prod   = PW'(rs) * PW'(mag);
        p      = SW'(prod >> (DW - 1));
        is_zero = (p == '0);
        is_full = (p >= SW'(vm));
        num    = (2*DW)'(ts) * (2*DW)'(p[DW-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_q <= 1'b1;
            full_q <= 1'b0;
            ts_l   <= '0;
        end else if (load) begin
            zero_q <= is_zero;
            full_q <= is_full;
            ts_l   <= ts;
        end
    end

    svm_frac_div #(.DW(DW)) u_div (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .num  (num),
        .den  (vm),
        .busy (busy),
        .quo  (quo)
    );

    assign off = zero_q ? '0 : (full_q ? ts_l : quo);

endmodule

// File: rtl/svm_dwell_solve.sv
// Solves the two dwell equations for one sector group.
module svm_dwell_solve
    import svm_dwell_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] off_a,
    input  logic [DW-1:0] off_b,
    input  logic [DW-1:0] ts,
    input  logic          swap,
    output logic [DW-1:0] t1,
    output logic [DW-1:0] t2,
    output logic [DW-1:0] t0,
    output logic          ok
);
    localparam int KW = 2 * DW;

    logic [DW-1:0]        half_src, rest_src;
    logic [DW:0]          scaled;
    logic signed [DW+1:0] t2s;

    always_comb begin
        half_src = swap ? off_a : off_b;
        rest_src = swap ? off_b : off_a;
        t1       = half_src >> 1;
        scaled   = (DW+1)'((KW'(t1) * KW'(SQRT3_Q)) >> SQRT3_FRAC);
        t2s      = $signed({2'b00, rest_src}) - $signed({1'b0, scaled});
        t2       = t2s[DW-1:0];
        ok       = (off_a != '0) && (off_b != '0) && (t2s > 0);
        t0       = ts - t1 - t2;
    end

endmodule

// File: rtl/svm_dwell_sync.sv
module svm_dwell_sync
    import svm_dwell_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic signed [DW-1:0]   i_alpha,
    input  logic signed [DW-1:0]   i_beta,
    input  logic [DW-1:0]          rs_gain,
    input  logic [DW-1:0]          v_ctrl,
    input  logic [DW-1:0]          period_cnt,
    output logic [SECTOR_BITS-1:0] sector,
    output logic [5:0]             vec_pair,
    output logic [DW-1:0]          t1,
    output logic [DW-1:0]          t2,
    output logic [DW-1:0]          t0,
    output logic                   done,
    output logic                   fault
);
    localparam sector_t LAST_TRY = sector_t'(SECTOR_COUNT - 1);

    state_t               state_q;
    sector_t              trial_q, tries_q;
    logic signed [DW-1:0] ia_q, ib_q;
    logic [DW-1:0]        rs_q, vm_q, ts_q;
    fold_t                fold;
    logic                 load, any_busy;

    logic signed [DW-1:0] samp   [AXES];
    logic                 neg_v  [AXES];
    logic                 busy_v [AXES];
    logic [DW-1:0]        off_v  [AXES];

    logic [DW-1:0]        s_t1, s_t2, s_t0;
    logic                 s_ok;

    assign fold     = sector_fold(trial_q);
    assign load     = (state_q == ST_LOAD);
    assign samp[0]  = ia_q;
    assign samp[1]  = ib_q;
    assign neg_v[0] = fold.neg_a;
    assign neg_v[1] = fold.neg_b;
    assign any_busy = busy_v[0] | busy_v[1];

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        svm_axis_offtime #(.DW(DW)) u_axis (
            .clk    (clk),
            .rst    (rst),
            .load   (load),
            .sample (samp[g]),
            .neg    (neg_v[g]),
            .rs     (rs_q),
            .vm     (vm_q),
            .ts     (ts_q),
            .busy   (busy_v[g]),
            .off    (off_v[g])
        );
    end

    svm_dwell_solve #(.DW(DW)) u_solve (
        .off_a (off_v[0]),
        .off_b (off_v[1]),
        .ts    (ts_q),
        .swap  (fold.swap),
        .t1    (s_t1),
        .t2    (s_t2),
        .t0    (s_t0),
        .ok    (s_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            trial_q <= '0;
            tries_q <= '0;
            ia_q    <= '0;
            ib_q    <= '0;
            rs_q    <= '0;
            vm_q    <= '0;
            ts_q    <= '0;
            sector  <= '0;
            t1      <= '0;
            t2      <= '0;
            t0      <= '0;
            done    <= 1'b0;
            fault   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ia_q    <= i_alpha;
                        ib_q    <= i_beta;
                        rs_q    <= rs_gain;
                        vm_q    <= v_ctrl;
                        ts_q    <= period_cnt;
                        trial_q <= sector;
                        tries_q <= '0;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (!any_busy) state_q <= ST_SOLVE;
                end
                default: begin
                    if (s_ok) begin
                        sector  <= trial_q;
                        t1      <= s_t1;
                        t2      <= s_t2;
                        t0      <= s_t0;
                        fault   <= 1'b0;
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (tries_q == LAST_TRY) begin
                        t1      <= '0;
                        t2      <= '0;
                        t0      <= ts_q;
                        fault   <= 1'b1;
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        trial_q <= sector_next(trial_q);
                        tries_q <= tries_q + sector_t'(1);
                        state_q <= ST_LOAD;
                    end
                end
            endcase
        end
    end

    assign vec_pair = sector_pair(sector);

endmodule

// File: rtl/svm_dwell_sync_chk.sv
module svm_dwell_sync_chk
    import svm_dwell_pkg::*;
#(
    parameter int DW = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   done,
    input logic                   fault,
    input logic [SECTOR_BITS-1:0] sector,
    input logic [5:0]             vec_pair,
    input logic [DW-1:0]          t1,
    input logic [DW-1:0]          t2,
    input logic [DW-1:0]          t0,
    input logic [DW-1:0]          ts_q
);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({sector, vec_pair, t1, t2, t0, fault}));

    a_r8_period_filled: assert property (@(posedge clk) disable iff (rst)
        done |-> (32'(t0) + 32'(t1) + 32'(t2)) == 32'(ts_q));

    a_r9_fault_null: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (t1 == '0 && t2 == '0 && t0 == ts_q));

    a_r9_fault_keeps_sector: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> sector == $past(sector));

    a_r7_second_dwell_positive: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> t2 != '0);

    a_r12_distinct_vectors: assert property (@(posedge clk) disable iff (rst)
        vec_pair[5:3] != vec_pair[2:0]);

endmodule

bind svm_dwell_sync svm_dwell_sync_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .fault    (fault),
    .sector   (sector),
    .vec_pair (vec_pair),
    .t1       (t1),
    .t2       (t2),
    .t0       (t0),
    .ts_q     (ts_q)
);

// File: tb/svm_dwell_sync_tb.sv
module svm_dwell_sync_tb;

    localparam int STEP = 19;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst, start;
    logic signed [15:0] i_alpha, i_beta;
    logic [15:0]        rs_gain, v_ctrl, period_cnt;
    logic [2:0]         sector;
    logic [5:0]         vec_pair;
    logic [15:0]        t1, t2, t0;
    logic               done, fault;

    svm_dwell_sync u_dut (
        .clk(clk), .rst(rst), .start(start),
        .i_alpha(i_alpha), .i_beta(i_beta),
        .rs_gain(rs_gain), .v_ctrl(v_ctrl), .period_cnt(period_cnt),
        .sector(sector), .vec_pair(vec_pair),
        .t1(t1), .t2(t2), .t0(t0), .done(done), .fault(fault)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state (what the outputs should show)
    int m_sec = 0, m_t1 = 0, m_t2 = 0, m_t0 = 0;
    bit m_fault = 0;

    function automatic void chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endfunction

    // R12 table
    function automatic int pair_of(int s);
        case (s)
            0: return 'o12;
            1: return 'o23;
            2: return 'o32;
            3: return 'o34;
            4: return 'o45;
            5: return 'o56;
            6: return 'o65;
            default: return 'o61;
        endcase
    endfunction

    // R4 off-time
    function automatic longint off_of(longint p, longint vm, longint ts);
        if (p == 0) return 0;
        if (p >= vm) return ts;
        return (ts * p) / vm;
    endfunction

    // R3, R5, R6, R7: one sector attempt
    function automatic void try_sector(input int sec, input longint ia, ib, rs, vm, ts,
                                       output bit ok, output longint a1, a2);
        longint ma, mb, oa, ob, half_v, rest_v;
        ma = (sec >= 2 && sec <= 5) ? -ia : ia;
        mb = (sec >= 4) ? -ib : ib;
        if (ma < 0) ma = 0;
        if (mb < 0) mb = 0;
        oa = off_of((rs * ma) / 32768, vm, ts);
        ob = off_of((rs * mb) / 32768, vm, ts);
        if (sec == 1 || sec == 2 || sec == 5 || sec == 6) begin
            half_v = oa; rest_v = ob;
        end else begin
            half_v = ob; rest_v = oa;
        end
        a1 = half_v / 2;
        a2 = rest_v - (a1 * 28378) / 16384;
        ok = (oa > 0) && (ob > 0) && (a2 > 0);
    endfunction

    task automatic check_outputs(string req, bit exp_done);
        chk(done == exp_done, "R10", "done", done, exp_done);
        chk(sector == m_sec[2:0] && t1 == m_t1[15:0] && t2 == m_t2[15:0]
            && t0 == m_t0[15:0] && fault == m_fault, req, "outputs/sector",
            sector, m_sec);
    endtask

    task automatic run_period(input int ia, ib, rs, vm, ts, input bit poke, input string req);
        int trial, n, lat;
        bit acc;
        longint a1, a2;
        trial = m_sec; acc = 0; n = 0;
        for (int k = 0; k < 8 && !acc; k++) begin
            n = k + 1;
            try_sector(trial, ia, ib, rs, vm, ts, acc, a1, a2);
            if (!acc) trial = (trial + 1) % 8;
        end
        lat = STEP * n;

        @(negedge clk);
        start = 1'b1;
        i_alpha = 16'(ia); i_beta = 16'(ib);
        rs_gain = 16'(rs); v_ctrl = 16'(vm); period_cnt = 16'(ts);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        // R11: inputs changed after capture must not matter
        i_alpha = ~16'(ia); i_beta = 16'(ia); v_ctrl = 16'd7;

        for (int c = 1; c <= lat + 1; c++) begin
            @(posedge clk);
            #2;
            if (c < lat) begin
                check_outputs("R10", 1'b0);
            end else if (c == lat) begin
                if (acc) begin
                    m_sec = trial; m_t1 = int'(a1); m_t2 = int'(a2);
                    m_t0 = ts - int'(a1) - int'(a2); m_fault = 0;
                end else begin
                    m_t1 = 0; m_t2 = 0; m_t0 = ts; m_fault = 1;
                end
                chk(done == 1'b1, "R10", "done at 19*n", done, 1);
                chk(sector == m_sec[2:0], "R2", "sector", sector, m_sec);
                chk(t1 == m_t1[15:0] && t2 == m_t2[15:0], req, "t1/t2",
                    {t1, t2}, {m_t1[15:0], m_t2[15:0]});
                chk(t0 == m_t0[15:0], "R8", "t0", t0, m_t0);
                chk(fault == m_fault, "R9", "fault", fault, m_fault);
                chk(vec_pair == 6'(pair_of(m_sec)), "R12", "vec_pair", vec_pair, pair_of(m_sec));
            end else begin
                check_outputs(req, 1'b0);
            end
            if (poke && c == 3) begin
                // R11: retrigger during search with other inputs
                start = 1'b1; i_alpha = 16'sd0; i_beta = 16'sd0; v_ctrl = 16'd1;
            end
            if (poke && c == 4) start = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0;
        i_alpha = '0; i_beta = '0; rs_gain = '0; v_ctrl = '0; period_cnt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        // R1 reset state
        chk(sector == 3'd0, "R1", "sector", sector, 0);
        chk(t1 == 0 && t2 == 0 && t0 == 0, "R1", "times", {t1, t2, t0}, 0);
        chk(done == 0 && fault == 0, "R1", "flags", {done, fault}, 0);
        chk(vec_pair == 6'o12, "R1", "vec_pair", vec_pair, 'o12);

        // R5: shallow angle, first quadrant, accepted at once
        run_period(20000, 4000, 16384, 20000, 1000, 0, "R5");
        // R6/R7: steep angle, group A rejects, exchanged group accepts
        run_period(4000, 20000, 16384, 20000, 1000, 0, "R6");
        // R3: third quadrant, several rejections
        run_period(-15000, -3000, 16384, 20000, 1000, 0, "R3");
        // R3/R6: fourth quadrant steep
        run_period(3000, -15000, 16384, 20000, 1000, 0, "R6");
        // R7: fourth quadrant shallow, reaches code 7
        run_period(15000, -3000, 16384, 20000, 1000, 0, "R7");
        // R2: wrap from code 7 to code 0
        run_period(15000, 2000, 16384, 20000, 1000, 0, "R2");
        // R9: no valid sector
        run_period(0, 0, 16384, 20000, 1000, 0, "R9");
        // R9: fault clears on next acceptance
        run_period(6000, 9000, 16384, 20000, 1000, 0, "R9");
        // R4: saturated off-time, p >= Vm
        run_period(30000, 30000, 32768, 1000, 800, 0, "R4");
        // R4: Vm of zero saturates
        run_period(12000, 500, 20000, 0, 640, 0, "R4");
        // R4: tiny beta scales to zero, forcing rejection
        run_period(20000, 1, 16384, 20000, 1000, 0, "R4");
        // R11: retrigger ignored, inputs latched
        run_period(-32768, 10000, 16384, 30000, 1234, 1, "R11");
        // R5: second quadrant shallow
        run_period(-20000, 3000, 16384, 25000, 1500, 0, "R5");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule